// File: doc/BRIEF.md
# Channel Status and Break Controller

This block holds the status and control word of one logical channel on a serial media bus. It shows two buffer flags that come from the local channel buffer. It also keeps a set of sticky event flags: hardware sets them, and software clears them by writing a one. Software can ask for a break, and the block then carries out a short hardware sequence that depends on the channel's type and direction.

For asynchronous and control channels, a break request produces one command byte on a valid/ready command port. A transmitting channel sends an asynchronous break (0x26) or a control break (0x36). A receiving channel sends receiver-break status (0x70). For an isochronous receive channel, a separate request ends the current packet and flushes the buffer for one cycle. It also clears the ready bit and stores a 2-bit code that tells software where the last valid byte sits.

A single write strobe and an always-valid read word form the register port. The buffer memory and the bus framing sit outside this block.

Top module: `chan_stat_brk`

## Requirements
- R1: The read word shows the buffer-empty flag at bit 31 and the buffer-full flag at bit 30. Each flag is the buffer input registered once. Reset sets empty to 1 and full to 0, and software writes to these bits have no effect.
- R2: On a transmit channel (cfg_tx=1), a break request (write 1 to bit 26) issues command 0x26 when cfg_kind=2'b10 (asynchronous) and 0x36 when cfg_kind=2'b11 (control).
- R3: On a receive channel (cfg_tx=0) of kind asynchronous or control, a break request issues status 0x70.
- R4: Break bit 26 reads 1, and cmd_valid stays high, until the cycle in which cmd_ready is high. The bit then clears. A second request while one is pending produces no second command.
- R5: A request that the channel type does not allow is dropped, and the bit never reads 1. This covers a break (bit 26) on kinds 2'b00 (synchronous) or 2'b01 (isochronous), and an isochronous break (bit 27) on anything other than an isochronous receive channel.
- R6: An isochronous break (write 1 to bit 27, cfg_kind=2'b01, cfg_tx=0) raises buf_flush for exactly one cycle. In the cycle after that, bit 27 and the ready bit (bit 25) both read 0.
- R7: At the flush, bits 29:28 load the count of partial-packet bytes minus one, clamped to 0..3. A count of 0 or 1 gives 0, and a count of 4 or more gives 3.
- R8: Event flags at bits NUM_EVT-1:0 set on a one-cycle evt_set pulse. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: When hardware and software act on one bit in the same cycle, hardware wins. A flush clears the ready bit even while software writes it to 1, and an event set beats a one-to-clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx | input | 1 | Channel direction, 1 = transmit |
| cfg_kind | input | 2 | Channel kind: 00 sync, 01 isochronous, 10 async, 11 control |
| buf_empty | input | 1 | Buffer-empty state from the channel buffer |
| buf_full | input | 1 | Buffer-full state from the channel buffer |
| evt_set | input | NUM_EVT | One-cycle pulses that set event flags |
| part_cnt | input | CNT_W | Bytes received in the current partial packet |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read word |
| cmd_valid | output | 1 | Break command pending |
| cmd_code | output | 8 | Break command byte |
| cmd_ready | input | 1 | Bus accepts the command |
| buf_flush | output | 1 | One-cycle flush of the channel buffer |

## Verification
The bench holds cmd_ready low while a break is pending. A design that dropped the request before the handshake would lose the command, and one that re-armed on a second write would send two. It sweeps the partial-packet count over 0, 1, 2, 3, 4 and 7, so a missing clamp or an off-by-one shows up as a wrong 2-bit code. It writes the ready bit in the very cycle of a flush, and clears an event flag in the same cycle that hardware sets it. A design that let software win either conflict would read back the wrong value. Requests on channel types that do not allow them must leave the bit at 0 and send nothing, so a missing type check shows up as a stray command or flush.

// File: rtl/chan_stat_pkg.sv
package chan_stat_pkg;

    typedef enum logic [1:0] {
        KIND_SYNC  = 2'b00,
        KIND_ISO   = 2'b01,
        KIND_ASYNC = 2'b10,
        KIND_CTRL  = 2'b11
    } chan_kind_e;

    localparam logic [7:0] CODE_ASYNC_BRK = 8'h26;
    localparam logic [7:0] CODE_CTRL_BRK  = 8'h36;
    localparam logic [7:0] CODE_RX_BRK    = 8'h70;

    localparam int POS_EMPTY  = 31;
    localparam int POS_FULL   = 30;
    localparam int POS_VB_HI  = 29;
    localparam int POS_VB_LO  = 28;
    localparam int POS_ISOBRK = 27;
    localparam int POS_BRK    = 26;
    localparam int POS_RDY    = 25;

    function automatic logic [7:0] brk_code(input logic tx, input chan_kind_e k);
        if (!tx)            return CODE_RX_BRK;
        else if (k == KIND_CTRL) return CODE_CTRL_BRK;
        else                return CODE_ASYNC_BRK;
    endfunction

    function automatic logic brk_allowed(input chan_kind_e k);
        return (k == KIND_ASYNC) || (k == KIND_CTRL);
    endfunction

    function automatic logic isobrk_allowed(input logic tx, input chan_kind_e k);
        return !tx && (k == KIND_ISO);
    endfunction

    function automatic logic [1:0] vb_code(input int unsigned n);
        if (n <= 1)      return 2'd0;
        else if (n >= 4) return 2'd3;
        else             return 2'(n - 1);
    endfunction

endpackage

// File: rtl/evt_flags.sv
module evt_flags #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (hw_set[i])
                flags[i] <= 1'b1;
            else if (sw_clr[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/brk_seq.sv
module brk_seq
    import chan_stat_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_brk,
    input  logic             wr_isobrk,
    input  logic             wr_rdy,
    input  logic             cfg_tx,
    input  chan_kind_e       cfg_kind,
    input  logic [CNT_W-1:0] part_cnt,
    input  logic             cmd_ready,
    output logic             cmd_valid,
    output logic [7:0]       cmd_code,
    output logic             flush,
    output logic             brk_q,
    output logic             isobrk_q,
    output logic             rdy_q,
    output logic [1:0]       vb_q
);
    logic brk_req_ok;
    logic iso_req_ok;

    assign brk_req_ok = wr_en && wr_brk && brk_allowed(cfg_kind);
    assign iso_req_ok = wr_en && wr_isobrk && isobrk_allowed(cfg_tx, cfg_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_q    <= 1'b0;
            isobrk_q <= 1'b0;
            rdy_q    <= 1'b0;
            vb_q     <= 2'd0;
        end else begin
            if (brk_q) begin
                if (cmd_ready)
                    brk_q <= 1'b0;
            end else if (brk_req_ok) begin
                brk_q <= 1'b1;
            end

            if (isobrk_q)
                isobrk_q <= 1'b0;
            else if (iso_req_ok)
                isobrk_q <= 1'b1;

            if (isobrk_q)
                rdy_q <= 1'b0;
            else if (wr_en)
                rdy_q <= wr_rdy;

            if (isobrk_q)
                vb_q <= vb_code(32'(part_cnt));
        end
    end

    assign cmd_valid = brk_q;
    assign cmd_code  = brk_code(cfg_tx, cfg_kind);
    assign flush     = isobrk_q;
endmodule

// File: rtl/chan_stat_brk.sv
module chan_stat_brk
    import chan_stat_pkg::*;
#(
    parameter int NUM_EVT = 11,
    parameter int CNT_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_tx,
    input  logic [1:0]         cfg_kind,
    input  logic               buf_empty,
    input  logic               buf_full,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic [CNT_W-1:0]   part_cnt,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               cmd_valid,
    output logic [7:0]         cmd_code,
    input  logic               cmd_ready,
    output logic               buf_flush
);
    chan_kind_e         kind;
    logic               empty_q, full_q;
    logic [NUM_EVT-1:0] flags;
    logic [NUM_EVT-1:0] clr_mask;
    logic               brk_q, isobrk_q, rdy_q;
    logic [1:0]         vb_q;
    logic               unused_wbits;

    assign kind         = chan_kind_e'(cfg_kind);
    assign clr_mask     = reg_wr ? reg_wdata[NUM_EVT-1:0] : '0;
    assign unused_wbits = ^{reg_wdata[31:28], reg_wdata[24:NUM_EVT]};

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
            full_q  <= 1'b0;
        end else begin
            empty_q <= buf_empty;
            full_q  <= buf_full;
        end
    end

    evt_flags #(.N(NUM_EVT)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .hw_set (evt_set),
        .sw_clr (clr_mask),
        .flags  (flags)
    );

    brk_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .wr_brk    (reg_wdata[POS_BRK]),
        .wr_isobrk (reg_wdata[POS_ISOBRK]),
        .wr_rdy    (reg_wdata[POS_RDY]),
        .cfg_tx    (cfg_tx),
        .cfg_kind  (kind),
        .part_cnt  (part_cnt),
        .cmd_ready (cmd_ready),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .flush     (buf_flush),
        .brk_q     (brk_q),
        .isobrk_q  (isobrk_q),
        .rdy_q     (rdy_q),
        .vb_q      (vb_q)
    );

    always_comb begin
        reg_rdata                      = '0;
        reg_rdata[POS_EMPTY]           = empty_q;
        reg_rdata[POS_FULL]            = full_q;
        reg_rdata[POS_VB_HI:POS_VB_LO] = vb_q;
        reg_rdata[POS_ISOBRK]          = isobrk_q;
        reg_rdata[POS_BRK]             = brk_q;
        reg_rdata[POS_RDY]             = rdy_q;
        reg_rdata[NUM_EVT-1:0]         = flags;
    end
endmodule

// File: rtl/chan_stat_brk_chk.sv
module chan_stat_brk_chk
    import chan_stat_pkg::*;
#(
    parameter int NUM_EVT = 11,
    parameter int CNT_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_tx,
    input logic [1:0]         cfg_kind,
    input logic               buf_empty,
    input logic [NUM_EVT-1:0] evt_set,
    input logic [CNT_W-1:0]   part_cnt,
    input logic [31:0]        reg_rdata,
    input logic               cmd_valid,
    input logic [7:0]         cmd_code,
    input logic               cmd_ready,
    input logic               buf_flush
);
    assert_flag_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_rdata[31] && !reg_rdata[30]));

    assert_empty_follow_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (reg_rdata[31] == $past(buf_empty)));

    assert_tx_code_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cfg_tx) |-> (cmd_code == ((cfg_kind == 2'b11) ? 8'h36 : 8'h26)));

    assert_rx_code_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cfg_tx) |-> (cmd_code == 8'h70));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> cmd_valid);

    assert_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    assert_kind_ok_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cfg_kind[1]);

    assert_flush_once_R6: assert property (@(posedge clk) disable iff (rst)
        buf_flush |=> (!buf_flush && !reg_rdata[25] && !reg_rdata[27]));

    assert_vb_load_R7: assert property (@(posedge clk) disable iff (rst)
        buf_flush |=> (reg_rdata[29:28] == vb_code(32'($past(part_cnt)))));

    assert_evt_set_R8: assert property (@(posedge clk) disable iff (rst)
        (|evt_set) |=> ((reg_rdata[NUM_EVT-1:0] & $past(evt_set)) == $past(evt_set)));
endmodule

bind chan_stat_brk chan_stat_brk_chk #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_tx    (cfg_tx),
    .cfg_kind  (cfg_kind),
    .buf_empty (buf_empty),
    .evt_set   (evt_set),
    .part_cnt  (part_cnt),
    .reg_rdata (reg_rdata),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_ready (cmd_ready),
    .buf_flush (buf_flush)
);

// File: tb/chan_stat_brk_test.sv
module chan_stat_brk_test;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 11;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_tx = 1'b0;
    logic [1:0]    cfg_kind = 2'b00;
    logic          buf_empty = 1'b1;
    logic          buf_full = 1'b0;
    logic [NE-1:0] evt_set = '0;
    logic [CW-1:0] part_cnt = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          cmd_valid;
    logic [7:0]    cmd_code;
    logic          cmd_ready = 1'b1;
    logic          buf_flush;

    int vec_cnt = 0;
    int miss_cnt = 0;
    bit done = 1'b0;
    logic [8:0] exp_q[$];
    bit         pend_vb = 1'b0;
    logic [1:0] pend_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_stat_brk #(.NUM_EVT(NE), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .cfg_tx(cfg_tx), .cfg_kind(cfg_kind),
        .buf_empty(buf_empty), .buf_full(buf_full), .evt_set(evt_set),
        .part_cnt(part_cnt), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_ready(cmd_ready), .buf_flush(buf_flush)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            miss_cnt++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    endtask

    // all driver tasks are entered and left at a falling edge
    task automatic wr(input logic [31:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_code(input logic tx, input logic [1:0] k);
        if (!tx) return 8'h70;
        return (k == 2'b11) ? 8'h36 : 8'h26;
    endfunction

    function automatic logic [1:0] exp_vb(input int c);
        if (c < 2) return 2'd0;
        if (c - 1 > 3) return 2'd3;
        return 2'(c - 1);
    endfunction

    task automatic do_break(input logic tx, input logic [1:0] k);
        cfg_tx = tx;
        cfg_kind = k;
        exp_q.push_back({1'b0, exp_code(tx, k)});
        wr(32'h1 << 26);
        idle(3);
        chk("R4 break bit cleared after accept", {31'd0, reg_rdata[26]}, 32'd0);
    endtask

    task automatic do_isobrk(input int c);
        part_cnt = CW'(c);
        wr(32'h1 << 25);
        chk("R6 ready bit set by software", {31'd0, reg_rdata[25]}, 32'd1);
        exp_q.push_back({1'b1, 6'd0, exp_vb(c)});
        wr(32'h1 << 27);
        idle(3);
        chk("R6 ready and iso break bits cleared", {30'd0, reg_rdata[27], reg_rdata[25]}, 32'd0);
    endtask

    // scoreboard monitor: samples a quarter period after each falling edge
    always begin
        logic [8:0] it;
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (!rst) begin
            if (pend_vb) begin
                chk("R7 valid-byte code", {30'd0, reg_rdata[29:28]}, {30'd0, pend_val});
                pend_vb = 1'b0;
            end
            if (cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected command", {24'd0, cmd_code}, 32'hFFFF_FFFF);
                end else begin
                    it = exp_q.pop_front();
                    chk("R2_R3 command byte", {23'd0, 1'b0, cmd_code}, {23'd0, it});
                end
            end
            if (buf_flush) begin
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected flush", 32'd1, 32'd0);
                end else begin
                    it = exp_q.pop_front();
                    chk("R6 flush expected", {31'd0, it[8]}, 32'd1);
                    pend_vb = 1'b1;
                    pend_val = it[1:0];
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            miss_cnt++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1: reset values
        chk("R1 reset read word", reg_rdata, 32'h8000_0000);
        chk("R4 no command after reset", {31'd0, cmd_valid}, 32'd0);

        // R1/R5: all-ones write on a sync rx channel only sets ready
        wr(32'hFFFF_FFFF);
        chk("R1_R5 all-ones write", reg_rdata, 32'h8200_0000);
        wr(32'h0);
        chk("R1 ready cleared by zero write", reg_rdata, 32'h8000_0000);

        // R1: buffer flags follow the inputs
        buf_empty = 1'b0;
        buf_full = 1'b1;
        idle(1);
        chk("R1 flags follow buffer", reg_rdata[31:30], 2'b01);
        buf_empty = 1'b1;
        buf_full = 1'b0;
        idle(1);
        chk("R1 flags back to empty", reg_rdata[31:30], 2'b10);

        // R2, R3: break codes
        do_break(1'b1, 2'b10);
        do_break(1'b1, 2'b11);
        do_break(1'b0, 2'b10);
        do_break(1'b0, 2'b11);

        // R4: hold while not ready
        cmd_ready = 1'b0;
        cfg_tx = 1'b1;
        cfg_kind = 2'b11;
        exp_q.push_back({1'b0, 8'h36});
        wr(32'h1 << 26);
        idle(3);
        chk("R4 valid held while not ready", {31'd0, cmd_valid}, 32'd1);
        chk("R4 bit held while not ready", {31'd0, reg_rdata[26]}, 32'd1);
        wr(32'h1 << 26);
        idle(1);
        cmd_ready = 1'b1;
        idle(3);
        chk("R4 bit cleared once accepted", {31'd0, reg_rdata[26]}, 32'd0);
        chk("R4 single command", exp_q.size(), 32'd0);

        // R5: disallowed requests
        cfg_tx = 1'b1;
        cfg_kind = 2'b01;
        wr(32'h1 << 26);
        chk("R5 break on iso never set", {31'd0, reg_rdata[26]}, 32'd0);
        cfg_kind = 2'b00;
        wr(32'h1 << 26);
        chk("R5 break on sync never set", {31'd0, reg_rdata[26]}, 32'd0);
        cfg_kind = 2'b01;
        wr(32'h1 << 27);
        chk("R5 iso break on iso tx never set", {31'd0, reg_rdata[27]}, 32'd0);
        cfg_tx = 1'b0;
        cfg_kind = 2'b10;
        wr(32'h1 << 27);
        chk("R5 iso break on async rx never set", {31'd0, reg_rdata[27]}, 32'd0);
        idle(2);

        // R6, R7: isochronous receive break with count sweep
        cfg_tx = 1'b0;
        cfg_kind = 2'b01;
        do_isobrk(0);
        do_isobrk(1);
        do_isobrk(2);
        do_isobrk(3);
        do_isobrk(4);
        do_isobrk(7);

        // R9: software sets ready in the flush cycle
        part_cnt = 3'd3;
        exp_q.push_back({1'b1, 6'd0, 2'd2});
        wr(32'h1 << 27);
        wr(32'h1 << 25);
        idle(2);
        chk("R9 flush beats ready write", {31'd0, reg_rdata[25]}, 32'd0);

        // R8: event flags
        evt_set = 11'h5A5;
        idle(1);
        evt_set = '0;
        chk("R8 events set", {21'd0, reg_rdata[10:0]}, 32'h5A5);
        wr(32'h0);
        chk("R8 zero write keeps events", {21'd0, reg_rdata[10:0]}, 32'h5A5);
        wr(32'h0A1);
        chk("R8 one-to-clear", {21'd0, reg_rdata[10:0]}, 32'h504);
        evt_set = 11'h002;
        wr(32'h002);
        evt_set = '0;
        chk("R9 set beats clear", {21'd0, reg_rdata[10:0]}, 32'h506);
        wr(32'h7FF);
        chk("R8 all cleared", {21'd0, reg_rdata[10:0]}, 32'h0);

        idle(3);
        chk("R2 scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        finish_run();
    end
endmodule